// File: doc/BRIEF.md
# Flash-to-FPGA Configuration Loader

This controller copies a configuration image, one byte at a time, from a byte-wide parallel flash into the serial configuration port of a target FPGA. It starts a load in one of three ways. The first is the release of reset at power-on. The second is a pulse from the board's reset button. The third is a pulse from a software reload request. Every load reads the same fixed page, which begins at flash address 0.

A load first holds the target's configuration-reset line low for a set number of cycles. It then waits for the target to report that it is ready. After that it reads the flash one byte at a time, holding the read strobe low for a set access time before it takes the byte. Each byte goes out least significant bit first on a data line together with a configuration clock. The load ends when the target reports that it is configured. If the whole page has been sent and the target has not reported this, the load ends with an error flag instead.

The controller has three parts: a pacing timer, an address counter and a byte serialiser. A state machine sequences them. Start requests that arrive while a load is running are dropped; they are not stored.

Top module: `flash_cfg_loader`

## Requirements
- R1: A load starts from idle on the first clock after reset is released (power-on), or on a one-cycle pulse of `board_reload` or of `sw_reload`. `busy` rises on the clock edge that accepts the start.
- R2: Each load drives `tgt_rst_n` low for exactly RST_CYCLES consecutive cycles, starting in the first busy cycle, and then drives it high for the rest of the load.
- R3: After the reset pulse, the loader waits until `tgt_ready` is 1 before the first flash read. `flash_oe_n` stays 1 while `tgt_rst_n` is low and while the loader is waiting.
- R4: `flash_addr` is 0 at the start of every load. It goes up by exactly one after each byte that is not the last byte, and never goes past 2**PAGE_W-1.
- R5: For each byte, `flash_oe_n` is 0 for exactly ACCESS_CYCLES cycles. `flash_data` is taken in the last of those cycles.
- R6: A byte goes out least significant bit first, and each bit takes two cycles. `tgt_data` holds the bit in both cycles, with `tgt_clk` at 0 in the first cycle and at 1 in the second. Outside the shift phase, `tgt_clk` and `tgt_data` are 0.
- R7: `tgt_done` is sampled in the last cycle of each byte. If it is 1, the load ends: `load_done` becomes 1 and `busy` becomes 0. This check takes priority over the end-of-page check.
- R8: If the byte at address 2**PAGE_W-1 has been sent and `tgt_done` is 0, the load ends with `load_error` at 1.
- R9: Start pulses that arrive while `busy` is 1 have no effect on the running load. They are not remembered after the load ends.
- R10: `load_done` and `load_error` are cleared when a new load is accepted. They are never both 1, and neither is 1 while `busy` is 1.
- R11: A synchronous active-low reset puts the outputs into their idle state: `tgt_rst_n`=1, `flash_oe_n`=1, `tgt_clk`=0, `tgt_data`=0, `busy`=0, `load_done`=0, `load_error`=0 and `flash_addr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; its release starts the power-on load |
| board_reload | input | 1 | One-cycle start pulse from the board reset button |
| sw_reload | input | 1 | One-cycle start pulse from software |
| flash_addr | output | ADDR_W | Flash byte address |
| flash_oe_n | output | 1 | Flash read strobe, active low |
| flash_data | input | 8 | Byte read from the flash |
| tgt_rst_n | output | 1 | Configuration reset to the target FPGA, active low |
| tgt_ready | input | 1 | Target is ready to accept configuration data |
| tgt_clk | output | 1 | Configuration bit clock |
| tgt_data | output | 1 | Configuration serial data |
| tgt_done | input | 1 | Target reports that configuration is complete |
| busy | output | 1 | A load is in progress |
| load_done | output | 1 | The last load ended with the target configured |
| load_error | output | 1 | The last load reached the end of the page without the target configured |

## Verification
Almost any internal fault shows up at the ports within one byte period, so a cycle-accurate comparison is an effective check. A wrong access timer changes how long `flash_oe_n` is low. A corrupt address counter shows in `flash_addr` on the next byte. A wrong serialiser phase moves a `tgt_clk` edge or flips a `tgt_data` bit in the same cycle. A fault in the state sequence either moves the end of the load or selects the wrong outcome flag. That difference appears no later than the last cycle of the byte in which `tgt_done` is sampled. A start pulse that was wrongly stored would restart the load one cycle after it goes idle, and `busy` would show it.

// File: rtl/lc_pkg.sv
// Package for the configuration loader. It holds the sequencer state type.
// Assumes: nothing beyond a single clock domain.
package lc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRST,
        ST_WAIT,
        ST_READ,
        ST_SHIFT
    } lc_state_t;
endpackage

// File: rtl/lc_pace_timer.sv
// Down-counting timer that paces the phases of a load.
// A load sets it to (length - 1). It then counts down while enabled, and
// `zero` marks the final cycle of the phase.
// Assumes: a load and a decrement never happen in the same cycle.
module lc_pace_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Count register: load the phase length, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/lc_addr_counter.sv
// Flash address counter for a single page that starts at address 0.
// Assumes: the page size 2**PAGE_W fits into the ADDR_W address space.
module lc_addr_counter #(
    parameter int ADDR_W = 20,
    parameter int PAGE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'((64'd1 << PAGE_W) - 64'd1);

    logic [ADDR_W-1:0] addr_q;

    // Address register: clear at the start of a load, step once per byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            addr_q <= '0;
        else if (inc && addr_q != LAST_ADDR)
            addr_q <= addr_q + 1'b1;
    end

    assign addr    = addr_q;
    assign at_last = (addr_q == LAST_ADDR);
endmodule

// File: rtl/lc_byte_shifter.sv
// Serialiser that sends a byte out least significant bit first, two cycles per
// bit: the clock is low in the first cycle and high in the second.
// Assumes: `active` stays high for exactly 2*BYTE_W cycles after each load.
module lc_byte_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              active,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              last_cycle
);
    localparam int PH_W = $clog2(BYTE_W) + 1;

    logic [BYTE_W-1:0] byte_q;
    logic [PH_W-1:0]   ph_q;

    // Byte holding register: capture the flash byte at the end of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            byte_q <= '0;
        else if (load)
            byte_q <= byte_in;
    end

    // Phase counter: bit index in the upper bits, clock half in bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            ph_q <= '0;
        else if (active)
            ph_q <= ph_q + 1'b1;
    end

    assign ser_clk    = active & ph_q[0];
    assign ser_data   = active & byte_q[ph_q[PH_W-1:1]];
    assign last_cycle = active & (ph_q == PH_W'(2 * BYTE_W - 1));
endmodule

// File: rtl/flash_cfg_loader.sv
// Top level of the configuration loader. The state machine sequences the
// target reset pulse, the wait for ready, the timed flash reads and the
// serial transfer. It ends on the target's done signal or at the end of
// the page.
// Assumes: start pulses are synchronous to clk; tgt_ready and tgt_done are
// already synchronised.
module flash_cfg_loader #(
    parameter int ADDR_W        = 20,
    parameter int PAGE_W        = 16,
    parameter int RST_CYCLES    = 16,
    parameter int ACCESS_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              board_reload,
    input  logic              sw_reload,
    output logic [ADDR_W-1:0] flash_addr,
    output logic              flash_oe_n,
    input  logic [7:0]        flash_data,
    output logic              tgt_rst_n,
    input  logic              tgt_ready,
    output logic              tgt_clk,
    output logic              tgt_data,
    input  logic              tgt_done,
    output logic              busy,
    output logic              load_done,
    output logic              load_error
);
    import lc_pkg::*;

    localparam int TMAX  = (RST_CYCLES > ACCESS_CYCLES) ? RST_CYCLES : ACCESS_CYCLES;
    localparam int TMR_W = $clog2(TMAX + 1);
    localparam logic [TMR_W-1:0] RST_LOAD = TMR_W'(RST_CYCLES - 1);
    localparam logic [TMR_W-1:0] ACC_LOAD = TMR_W'(ACCESS_CYCLES - 1);

    lc_state_t        state_q;
    logic             por_pend_q;
    logic             done_q, err_q;
    logic             start_req;
    logic             tmr_load, tmr_dec, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             addr_clear, addr_inc, addr_last;
    logic             sh_load, sh_active, sh_last;

    assign start_req = por_pend_q | board_reload | sw_reload;

    // Timer and datapath controls, decoded from the state and its exit conditions.
    always_comb begin
        tmr_load   = 1'b0;
        tmr_val    = ACC_LOAD;
        tmr_dec    = 1'b0;
        addr_clear = 1'b0;
        addr_inc   = 1'b0;
        sh_load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    tmr_load   = 1'b1;
                    tmr_val    = RST_LOAD;
                    addr_clear = 1'b1;
                end
            end
            ST_TRST:  tmr_dec = 1'b1;
            ST_WAIT:  tmr_load = tgt_ready;
            ST_READ: begin
                tmr_dec = 1'b1;
                sh_load = tmr_zero;
            end
            ST_SHIFT: begin
                if (sh_last && !tgt_done && !addr_last) begin
                    addr_inc = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Sequencer: state transitions plus the power-on request and outcome flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            por_pend_q <= 1'b1;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        state_q    <= ST_TRST;
                        por_pend_q <= 1'b0;
                        done_q     <= 1'b0;
                        err_q      <= 1'b0;
                    end
                end
                ST_TRST:  if (tmr_zero)  state_q <= ST_WAIT;
                ST_WAIT:  if (tgt_ready) state_q <= ST_READ;
                ST_READ:  if (tmr_zero)  state_q <= ST_SHIFT;
                ST_SHIFT: begin
                    if (sh_last) begin
                        if (tgt_done) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else if (addr_last) begin
                            state_q <= ST_IDLE;
                            err_q   <= 1'b1;
                        end else begin
                            state_q <= ST_READ;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sh_active = (state_q == ST_SHIFT);

    lc_pace_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    lc_addr_counter #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (addr_clear),
        .inc     (addr_inc),
        .addr    (flash_addr),
        .at_last (addr_last)
    );

    lc_byte_shifter #(.BYTE_W(8)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sh_load),
        .byte_in    (flash_data),
        .active     (sh_active),
        .ser_clk    (tgt_clk),
        .ser_data   (tgt_data),
        .last_cycle (sh_last)
    );

    assign busy       = (state_q != ST_IDLE);
    assign tgt_rst_n  = (state_q != ST_TRST);
    assign flash_oe_n = (state_q != ST_READ);
    assign load_done  = done_q;
    assign load_error = err_q;
endmodule

// File: rtl/lc_loader_checker.sv
// Property checker for flash_cfg_loader. It is attached by bind and only
// observes the port signals.
// Assumes: the same clock and synchronous reset as the loader.
module lc_loader_checker #(
    parameter int ADDR_W     = 20,
    parameter int RST_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] flash_addr,
    input logic              flash_oe_n,
    input logic              tgt_rst_n,
    input logic              tgt_clk,
    input logic              busy,
    input logic              load_done,
    input logic              load_error
);
    int low_cnt;

    // Length of the current low pulse on the target reset line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= 0;
        else if (!tgt_rst_n)
            low_cnt <= low_cnt + 1;
        else
            low_cnt <= 0;
    end

    AST_RST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_rst_n) |-> (low_cnt == RST_CYCLES)); // R2
    AST_RST_PULSE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (low_cnt <= RST_CYCLES)); // R2
    AST_NO_READ_IN_TRST: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_rst_n |-> flash_oe_n); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_addr != $past(flash_addr)) |->
        ((flash_addr == $past(flash_addr) + 1'b1) || (flash_addr == '0))); // R4
    AST_CLK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_clk |-> busy); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_done && load_error)); // R10
    AST_FLAGS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_done || load_error) |-> !busy); // R10
endmodule

bind flash_cfg_loader lc_loader_checker #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flash_addr (flash_addr),
    .flash_oe_n (flash_oe_n),
    .tgt_rst_n  (tgt_rst_n),
    .tgt_clk    (tgt_clk),
    .busy       (busy),
    .load_done  (load_done),
    .load_error (load_error)
);

// File: tb/test_flash_cfg_loader.sv
module test_flash_cfg_loader;
    localparam int AW  = 20;
    localparam int PW  = 3;
    localparam int RC  = 3;
    localparam int AC  = 2;
    localparam int NB  = 1 << PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic board_reload = 1'b0, sw_reload = 1'b0;
    logic [AW-1:0] flash_addr;
    logic flash_oe_n;
    logic [7:0] flash_data;
    logic tgt_rst_n, tgt_ready, tgt_clk, tgt_data, tgt_done;
    logic busy, load_done, load_error;

    int checks = 0, failures = 0, cycles = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] fbyte(input int a);
        return 8'((a * 29) ^ 32'h5A);
    endfunction
    assign flash_data = fbyte(int'(flash_addr));

    flash_cfg_loader #(.ADDR_W(AW), .PAGE_W(PW), .RST_CYCLES(RC), .ACCESS_CYCLES(AC)) i_flash_cfg_loader (
        .clk(clk), .rst_n(rst_n), .board_reload(board_reload), .sw_reload(sw_reload),
        .flash_addr(flash_addr), .flash_oe_n(flash_oe_n), .flash_data(flash_data),
        .tgt_rst_n(tgt_rst_n), .tgt_ready(tgt_ready), .tgt_clk(tgt_clk), .tgt_data(tgt_data),
        .tgt_done(tgt_done), .busy(busy), .load_done(load_done), .load_error(load_error));

    // Target model settings
    int  ready_delay = 2;
    int  done_after  = 0;
    logic rdy_r = 1'b1, done_r = 1'b0, prev_clk = 1'b0;
    int  wcnt = 0, bits = 0;
    assign tgt_ready = rdy_r;
    assign tgt_done  = done_r;

    // Reference model: 0 idle, 1 target reset, 2 wait ready, 3 byte transfer
    int m_mode = 0, m_k = 0, m_b = 0;
    bit m_por = 1, m_done = 0, m_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_k = 0; m_b = 0; m_por = 1; m_done = 0; m_err = 0;
        end else begin
            case (m_mode)
                0: if (m_por || board_reload || sw_reload) begin
                       m_mode = 1; m_k = 0; m_b = 0; m_por = 0; m_done = 0; m_err = 0;
                   end
                1: if (m_k == RC - 1) m_mode = 2; else m_k++;
                2: if (tgt_ready) begin m_mode = 3; m_k = 0; end
                default: begin
                    if (m_k == AC + 15) begin
                        if (tgt_done) begin m_mode = 0; m_done = 1; end
                        else if (m_b == NB - 1) begin m_mode = 0; m_err = 1; end
                        else begin m_b++; m_k = 0; end
                    end else m_k++;
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Compare on every cycle, then update the target model
    always @(negedge clk) begin
        bit shifting;
        int e_clk, e_dat;
        cycles++;
        shifting = (m_mode == 3) && (m_k >= AC);
        e_clk = shifting ? ((m_k - AC) & 1) : 0;
        e_dat = shifting ? int'(fbyte(m_b)[(m_k - AC) >> 1]) : 0;
        if (rst_n) begin
            chk(busy == (m_mode != 0), "R1", "busy", busy, m_mode != 0);
            chk(tgt_rst_n == (m_mode != 1), "R2", "tgt_rst_n", tgt_rst_n, m_mode != 1);
            chk(flash_oe_n == !(m_mode == 3 && m_k < AC), "R5", "flash_oe_n", flash_oe_n, !(m_mode == 3 && m_k < AC));
            chk(int'(flash_addr) == m_b, "R4", "flash_addr", int'(flash_addr), m_b);
            chk(int'(tgt_clk) == e_clk, "R6", "tgt_clk", tgt_clk, e_clk);
            chk(int'(tgt_data) == e_dat, "R6", "tgt_data", tgt_data, e_dat);
            chk(load_done == m_done, "R7", "load_done", load_done, m_done);
            chk(load_error == m_err, "R8", "load_error", load_error, m_err);
        end
        // target FPGA behaviour
        if (!tgt_rst_n) begin
            rdy_r = 1'b0; wcnt = 0; bits = 0; done_r = 1'b0;
        end else if (!rdy_r) begin
            if (wcnt >= ready_delay) rdy_r = 1'b1; else wcnt++;
        end
        if (tgt_clk && !prev_clk) bits++;
        prev_clk = tgt_clk;
        if (done_after > 0 && bits == done_after * 8) done_r = 1'b1;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!busy && m_mode == 0) break;
        end
    endtask

    task automatic pulse(input bit brd, input bit sw);
        @(negedge clk);
        board_reload = brd; sw_reload = sw;
        @(negedge clk);
        board_reload = 1'b0; sw_reload = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(busy == 0 && load_done == 0 && load_error == 0, "R11", "status", {busy, load_done, load_error}, 0);
        chk(tgt_rst_n == 1 && flash_oe_n == 1 && tgt_clk == 0 && tgt_data == 0, "R11", "lines",
            {tgt_rst_n, flash_oe_n, tgt_clk, tgt_data}, 4'b1100);
        chk(flash_addr == 0, "R11", "addr", int'(flash_addr), 0);
        // R1 power-on load, target done after 3 bytes (R7)
        done_after = 3; ready_delay = 4;
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1, "R1", "power-on start", busy, 1);
        wait_idle();
        chk(load_done == 1 && load_error == 0, "R7", "done after 3 bytes", load_done, 1);
        chk(flash_addr == 2, "R4", "last addr", int'(flash_addr), 2);
        // R8: target never done -> error at page end
        done_after = 0; ready_delay = 1;
        pulse(1'b0, 1'b1);
        chk(load_done == 0, "R10", "done cleared at start", load_done, 0);
        wait_idle();
        chk(load_error == 1 && load_done == 0, "R8", "error at page end", load_error, 1);
        chk(flash_addr == NB - 1, "R8", "stop at last addr", int'(flash_addr), NB - 1);
        // R7: done on the final byte wins over end of page
        done_after = NB; ready_delay = 0;
        pulse(1'b1, 1'b0);
        wait_idle();
        chk(load_done == 1 && load_error == 0, "R7", "done priority", load_error, 0);
        // R9: triggers during a load are ignored and not remembered
        done_after = 2; ready_delay = 3;
        pulse(1'b0, 1'b1);
        repeat (20) @(negedge clk);
        pulse(1'b1, 1'b1);
        repeat (5) @(negedge clk);
        pulse(1'b0, 1'b1);
        wait_idle();
        chk(load_done == 1, "R9", "load completes undisturbed", load_done, 1);
        repeat (10) @(negedge clk);
        chk(busy == 0, "R9", "no stored restart", busy, 0);
        // R3: long ready wait
        done_after = 1; ready_delay = 30;
        pulse(1'b1, 1'b0);
        wait_idle();
        chk(load_done == 1, "R3", "load after long wait", load_done, 1);
        // R11 + R1: reset in mid-load restarts through power-on path
        done_after = 1; ready_delay = 2;
        pulse(1'b0, 1'b1);
        repeat (12) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(busy == 0 && tgt_rst_n == 1 && flash_oe_n == 1, "R11", "mid-load reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1, "R1", "restart after reset", busy, 1);
        wait_idle();
        chk(load_done == 1, "R1", "restart completes", load_done, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule